// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the protocol side of a byte-wide memory that sits on a two-wire serial bus as a slave. It oversamples the bus clock and data lines with the system clock and finds start and stop conditions and clock edges. It accepts a device-select byte whose low address bits must equal three strap inputs. It then takes a two-byte word address and performs single-byte and multi-byte writes, reads from the current address, random reads and sequential reads on an internal array of 4096 words (set by a parameter).

The block drives the data line only by pulling it low, through an output-enable. The outside pad logic combines this enable with the pull-up, so that the line reads low whenever the enable is high. A persistent word-address counter links transactions together. On writes only its five low bits advance, so a burst stays inside one 32-byte page. On reads the whole counter advances, so a burst crosses pages and wraps from the top of the array to zero. The system clock must run well above the bus clock rate.

Top module: `tw_eeprom_slave`

## Requirements
- R1: A start (data falling while clock is high) in any state abandons the current byte and begins device-select reception. A stop (data rising while clock is high) returns the block to idle with the data line released.
- R2: The device-select byte is taken MSB first as code 4'b1010, then three bits that must equal `strap_i[2:0]`, then a direction bit (1 = read). On any mismatch there is no acknowledge, and the block ignores all traffic until the next start, so memory is not changed.
- R3: The block acknowledges by pulling data low for the whole ninth clock after the device-select byte, after each word-address byte and after each write data byte.
- R4: After a write select, two word-address bytes follow, high byte first. Only the low AW bits (12 by default) are used, and the upper bits are ignored.
- R5: Each write data byte is stored at the counter, and then only the low 5 counter bits increment. After byte 31 of a page, the next byte goes to byte 0 of the same page and overwrites earlier data.
- R6: The counter keeps its value between transactions. A read with no address phase returns the byte at the last accessed address plus one.
- R7: A random read is a write select plus two address bytes, then a repeated start and a read select. It returns the byte at the loaded address.
- R8: Read data leaves MSB first. After each byte the full counter increments and wraps from address 4095 to 0. A master acknowledge (low) continues the burst, and a master no-acknowledge ends it.
- R9: The block changes the data-line enable only while the clock line is low.
- R10: The sequence start, nine clocks with data released, start, stop returns the block to idle from inside a transaction, ready for a new transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously inside |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND of all drivers) |
| strap_i | input | 3 | Board strap value compared against the device-select address bits |
| sda_oe_o | output | 1 | When high, the pad pulls the data line low |

## Verification
A corrupted bit counter shows up on the bus within one byte time, because the acknowledge lands on the wrong clock or does not come at all. A corrupted state register shows as a missing or extra acknowledge on the next byte. A wrong word-address counter does not show when the write happens. It appears only on a later read, as wrong data in the first byte that follows, and page or array wraps show it only at the 32-byte or 4096-byte boundary. For this reason the bench reads back every region it writes, including across both wrap points, and it sweeps all 128 device-select codes against a fixed strap value.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } tw_state_e;

  typedef enum logic [1:0] {
    CTR_HOLD,
    CTR_LOAD,
    CTR_PAGE,
    CTR_FULL
  } ctr_op_e;

endpackage

// File: rtl/tw_line_sync.sv
module tw_line_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] rise_o,
  output logic [LINES-1:0] fall_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // the bus idles high, so the synchronizer resets high
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '1;
        prev_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], raw_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr
  import tw_pkg::*;
#(
  parameter int AW = 12,
  parameter int PB = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctr_op_e       op_i,
  input  logic [AW-1:0] load_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [PB-1:0] low_step;

  assign low_step = addr_q[PB-1:0] + PB'(1);

  always_comb begin
    case (op_i)
      CTR_LOAD: addr_d = load_i;
      CTR_PAGE: addr_d = {addr_q[AW-1:PB], low_step};
      CTR_FULL: addr_d = addr_q + AW'(1);
      default:  addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                addr_q <= '0;
    else if (op_i != CTR_HOLD) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

  // R5: a write step never leaves the current page
  p_page_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_i == CTR_PAGE |=> addr_q[AW-1:PB] == $past(addr_q[AW-1:PB]));

  // R5: last byte of a page steps to byte 0 of that page
  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CTR_PAGE && (&addr_q[PB-1:0])) |=> addr_q[PB-1:0] == '0);

  // R8: read step from the top of the array lands on zero
  p_array_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == CTR_FULL && (&addr_q)) |=> addr_q == '0);

endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/tw_eeprom_slave.sv
module tw_eeprom_slave
  import tw_pkg::*;
#(
  parameter int         AW       = 12,
  parameter int         PB       = 5,
  parameter logic [3:0] DEV_CODE = 4'hA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  output logic       sda_oe_o
);

  localparam logic [3:0] BIT_LAST = 4'd8;
  localparam logic [3:0] ACK_SLOT = 4'd9;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s = rst_pipe_q[1];

  // bus line conditioning: index 0 clock, index 1 data
  logic [1:0] lvl, rise, fall;
  tw_line_sync #(.LINES(2), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_s),
    .raw_i  ({sda_i, scl_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_lvl   = lvl[0];
  assign sda_lvl   = lvl[1];
  assign scl_rise  = rise[0];
  assign scl_fall  = fall[0];
  assign start_evt = fall[1] & scl_lvl & ~scl_rise;
  assign stop_evt  = rise[1] & scl_lvl & ~scl_rise;

  tw_state_e     state_q, state_d;
  logic [3:0]    bc_q, bc_d;
  logic [7:0]    rx_q, rx_d, tx_q, tx_d, hi_q, hi_d;
  logic          oe_q, oe_d;
  ctr_op_e       ctr_op;
  logic          mem_we;
  logic [AW-1:0] ctr_addr;
  logic [7:0]    mem_rdata;
  logic [15:0]   word_addr;
  logic          addr_unused;
  logic          addr_match;
  logic [2:0]    tx_idx;

  assign word_addr   = {hi_q, rx_q};
  assign addr_unused = ^word_addr[15:AW];
  assign addr_match  = (rx_q[7:4] == DEV_CODE) && (rx_q[3:1] == strap_i);
  assign tx_idx      = 3'(4'd7 - bc_q);

  tw_addr_ctr #(.AW(AW), .PB(PB)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_s),
    .op_i   (ctr_op),
    .load_i (word_addr[AW-1:0]),
    .addr_o (ctr_addr)
  );

  tw_mem #(.AW(AW), .DW(8)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (ctr_addr),
    .wdata_i (rx_q),
    .raddr_i (ctr_addr),
    .rdata_o (mem_rdata)
  );

  always_comb begin
    state_d = state_q;
    bc_d    = bc_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    oe_d    = oe_q;
    hi_d    = hi_q;
    ctr_op  = CTR_HOLD;
    mem_we  = 1'b0;
    if (stop_evt) begin
      state_d = ST_IDLE;
      bc_d    = '0;
      oe_d    = 1'b0;
    end else if (start_evt) begin
      state_d = ST_DEV;
      bc_d    = '0;
      oe_d    = 1'b0;
    end else if (state_q == ST_RD) begin
      if (scl_rise && bc_q < BIT_LAST) begin
        bc_d = bc_q + 4'd1;
      end else if (scl_rise && bc_q == BIT_LAST) begin
        if (sda_lvl) begin
          state_d = ST_IDLE;
          bc_d    = '0;
        end else begin
          bc_d = ACK_SLOT;
        end
      end else if (scl_fall && bc_q == ACK_SLOT) begin
        tx_d = mem_rdata;
        oe_d = ~mem_rdata[7];
        bc_d = '0;
      end else if (scl_fall && bc_q == BIT_LAST) begin
        oe_d   = 1'b0;
        ctr_op = CTR_FULL;
      end else if (scl_fall) begin
        oe_d = ~tx_q[tx_idx];
      end
    end else if (state_q != ST_IDLE) begin
      if (scl_rise && bc_q < BIT_LAST) begin
        rx_d = {rx_q[6:0], sda_lvl};
        bc_d = bc_q + 4'd1;
      end else if (scl_fall && bc_q == ACK_SLOT) begin
        oe_d = 1'b0;
        bc_d = '0;
      end else if (scl_fall && bc_q == BIT_LAST) begin
        bc_d = ACK_SLOT;
        oe_d = 1'b1;
        case (state_q)
          ST_DEV: begin
            if (addr_match) begin
              state_d = rx_q[0] ? ST_RD : ST_AHI;
            end else begin
              state_d = ST_IDLE;
              bc_d    = '0;
              oe_d    = 1'b0;
            end
          end
          ST_AHI: begin
            hi_d    = rx_q;
            state_d = ST_ALO;
          end
          ST_ALO: begin
            ctr_op  = CTR_LOAD;
            state_d = ST_WR;
          end
          default: begin
            mem_we = 1'b1;
            ctr_op = CTR_PAGE;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      state_q <= ST_IDLE;
      bc_q    <= '0;
      rx_q    <= '0;
      tx_q    <= '0;
      hi_q    <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      bc_q    <= bc_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      hi_q    <= hi_d;
      oe_q    <= oe_d;
    end
  end

  assign sda_oe_o = oe_q;

  // R1: a start restarts device-select reception with the line released
  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rst_s)
    (start_evt && !stop_evt) |=> (state_q == ST_DEV && bc_q == 4'd0 && !oe_q));

  // R1: a stop always ends in idle with the line released
  p_stop_idle_r1: assert property (@(posedge clk) disable iff (!rst_s)
    stop_evt |=> (state_q == ST_IDLE && !oe_q));

  // R2: a select byte that does not match never gets an acknowledge
  p_no_ack_mismatch_r2: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == ST_DEV && scl_fall && bc_q == BIT_LAST && !addr_match && !start_evt && !stop_evt)
      |=> (!oe_q && state_q == ST_IDLE));

  // R3: outside a read, the line is pulled only in the acknowledge slot
  p_ack_slot_r3: assert property (@(posedge clk) disable iff (!rst_s)
    (oe_q && state_q != ST_RD) |-> bc_q == ACK_SLOT);

  // R9: the enable moves only while the clock line is low
  p_oe_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_s)
    (oe_q != $past(oe_q)) |-> !$past(scl_lvl));

endmodule

// File: tb/tw_eeprom_slave_bench.sv
module tw_eeprom_slave_bench;

  localparam int         AW    = 12;
  localparam int         DEPTH = 1 << AW;
  localparam int         Q     = 8;
  localparam int         H     = 16;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEVW  = {4'hA, STRAP, 1'b0};
  localparam logic [7:0] DEVR  = {4'hA, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic sda_oe;
  logic sda_bus;
  int   nchk = 0;
  int   nfail = 0;
  int   viol = 0;
  bit   done = 0;
  logic [7:0] mdl [DEPTH];
  int   mctr;
  logic prev_oe, prev_scl;

  assign sda_bus = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  tw_eeprom_slave #(.AW(AW)) u_tw_eeprom_slave (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (m_scl),
    .sda_i    (sda_bus),
    .strap_i  (STRAP),
    .sda_oe_o (sda_oe)
  );

  // R9 monitor: enable must not move across a sampled clock-high interval
  always @(negedge clk) begin
    if (rst_n === 1'b1 && prev_scl === 1'b1 && m_scl === 1'b1 && sda_oe !== prev_oe) viol++;
    prev_oe  <= sda_oe;
    prev_scl <= m_scl;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(output logic smp);
    wait_cyc(Q);
    m_scl = 1'b1;
    wait_cyc(H / 2);
    smp = sda_bus;
    wait_cyc(H / 2);
    m_scl = 1'b0;
    wait_cyc(Q);
  endtask

  task automatic bus_start();
    m_sda = 1'b1;
    wait_cyc(Q);
    m_scl = 1'b1;
    wait_cyc(Q);
    m_sda = 1'b0;
    wait_cyc(Q);
    m_scl = 1'b0;
    wait_cyc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0;
    wait_cyc(Q);
    m_scl = 1'b1;
    wait_cyc(Q);
    m_sda = 1'b1;
    wait_cyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i];
      pulse(d);
    end
    m_sda = 1'b1;
    pulse(ack);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    logic d;
    m_sda = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      pulse(d);
      b = {b[6:0], d};
    end
    m_sda = nack;
    pulse(d);
    m_sda = 1'b1;
  endtask

  // write burst; address high byte carries junk in its unused bits (R4)
  task automatic write_seq(input int addr, input int n, input int seed);
    logic ack;
    int   base;
    base = addr & (DEPTH - 1) & ~31;
    bus_start();
    send_byte(DEVW, ack);
    chk(ack == 1'b0, "R3 select ack", int'(ack), 0);
    send_byte({4'hD, 4'(addr >> 8)}, ack);
    chk(ack == 1'b0, "R3 addr-hi ack", int'(ack), 0);
    send_byte(8'(addr), ack);
    chk(ack == 1'b0, "R3 addr-lo ack", int'(ack), 0);
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'(seed + i * 7);
      send_byte(d, ack);
      chk(ack == 1'b0, "R3 data ack", int'(ack), 0);
      mdl[base | ((addr + i) & 31)] = d;
    end
    mctr = base | ((addr + n) & 31);
    bus_stop();
  endtask

  // dummy write of the address, then a repeated start (R7)
  task automatic load_addr(input int addr);
    logic ack;
    bus_start();
    send_byte(DEVW, ack);
    chk(ack == 1'b0, "R7 select ack", int'(ack), 0);
    send_byte({4'h0, 4'(addr >> 8)}, ack);
    chk(ack == 1'b0, "R7 addr-hi ack", int'(ack), 0);
    send_byte(8'(addr), ack);
    chk(ack == 1'b0, "R7 addr-lo ack", int'(ack), 0);
    mctr = addr & (DEPTH - 1);
    bus_start();
  endtask

  // read select then n bytes, the last one not acknowledged (R8)
  task automatic read_bytes(input int n, input string tag);
    logic       ack;
    logic [7:0] b;
    send_byte(DEVR, ack);
    chk(ack == 1'b0, "R3 read select ack", int'(ack), 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk(b === mdl[mctr], tag, int'(b), int'(mdl[mctr]));
      mctr = (mctr + 1) % DEPTH;
    end
    bus_stop();
  endtask

  initial begin
    logic ack, d;
    logic [7:0] b;
    m_scl = 1'b1;
    m_sda = 1'b1;
    rst_n = 1'b0;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(6);
    chk(sda_oe == 1'b0, "R1 released after reset", int'(sda_oe), 0);

    // R2: every select code against the fixed strap value
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 8; a++) begin
        bus_start();
        send_byte({4'(c), 3'(a), 1'b0}, ack);
        chk(ack == ((c == 10 && a == 5) ? 1'b0 : 1'b1), "R2 select match", int'(ack),
            (c == 10 && a == 5) ? 0 : 1);
        bus_stop();
      end
    end

    // R3 R4 R5: short burst, junk in unused address bits
    write_seq(12'h123, 3, 8'h31);
    // R4 R7 R8: random read of the same bytes with clean address bits
    load_addr(12'h123);
    read_bytes(3, "R4 R7 R8 random sequential read");

    // R6: one byte random, then current-address read continues
    load_addr(12'h123);
    read_bytes(1, "R7 single random read");
    bus_start();
    read_bytes(2, "R6 current address read");

    // R2: a write to a non-matching strap changes nothing
    bus_start();
    send_byte({4'hA, 3'b100, 1'b0}, ack);
    chk(ack == 1'b1, "R2 foreign select nack", int'(ack), 1);
    send_byte(8'h01, ack);
    chk(ack == 1'b1, "R2 ignored addr-hi", int'(ack), 1);
    send_byte(8'h23, ack);
    chk(ack == 1'b1, "R2 ignored addr-lo", int'(ack), 1);
    send_byte(8'h55, ack);
    chk(ack == 1'b1, "R2 ignored data", int'(ack), 1);
    bus_stop();
    load_addr(12'h123);
    read_bytes(1, "R2 memory untouched");

    // R5: 34 bytes from page offset 30 wrap inside the page
    write_seq(12'h05E, 34, 8'h03);
    bus_start();
    read_bytes(1, "R5 counter wrapped to page start");
    load_addr(12'h040);
    read_bytes(32, "R5 page contents after wrap");

    // R8: read across the top of the array
    write_seq(12'hFFE, 2, 8'hC4);
    write_seq(12'h000, 1, 8'h9A);
    load_addr(12'hFFE);
    read_bytes(3, "R8 array wrap on read");

    // R10: bus reset from inside an address phase
    bus_start();
    send_byte(DEVW, ack);
    send_byte(8'h00, ack);
    m_sda = 1'b0;
    for (int i = 0; i < 4; i++) pulse(d);
    bus_start();
    m_sda = 1'b1;
    for (int i = 0; i < 9; i++) pulse(d);
    bus_start();
    bus_stop();
    chk(sda_oe == 1'b0, "R10 idle after bus reset", int'(sda_oe), 0);
    load_addr(12'h040);
    read_bytes(1, "R10 transaction after bus reset");

    // R1: start in the middle of an address byte, then current read
    bus_start();
    send_byte(DEVW, ack);
    chk(ack == 1'b0, "R1 select before abort", int'(ack), 0);
    m_sda = 1'b1;
    for (int i = 0; i < 3; i++) pulse(d);
    bus_start();
    send_byte(DEVR, ack);
    chk(ack == 1'b0, "R1 select after abort", int'(ack), 0);
    recv_byte(1'b1, b);
    chk(b === mdl[mctr], "R1 read after abort", int'(b), int'(mdl[mctr]));
    mctr = (mctr + 1) % DEPTH;
    bus_stop();
    chk(sda_oe == 1'b0, "R1 released after stop", int'(sda_oe), 0);

    chk(viol == 0, "R9 enable moved while clock high", viol, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog (R1) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule